// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block sits beside an SDRAM command bus and watches the chip-select, row strobe, column strobe, write enable, bank address and A10 lines on every rising clock edge. It decodes each command and keeps a small state machine for every bank: idle, row active, reading, writing or precharging. Each command is judged against the state of the bank it addresses, and against the state of all banks for the global commands. A rule violation raises a one-cycle flag together with the bank number. Legal commands move the bank states forward.

Burst lengths, the CAS latency and the precharge time are parameters. Per-bank down-counters decide when a burst or a precharge completes. Auto-precharge is taken from A10 on a read or write, and all-bank precharge from A10 on a precharge. The monitor only observes the bus: it drives nothing toward the memory, ignores the data bus and does no refresh-interval accounting. While clock enable is low it freezes.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A synchronous active-high `rst` leaves every bank idle, `illegalFlag` low and `illegalBank` zero, visible after the edge that samples it.
- R2: A command is issued when `cke` is high and `csN` is low, and its kind is {rasN,casN,weN}: 111 NOP, 110 BST, 101 READ, 100 WRIT, 011 ACT, 010 PRE, 001 REF, 000 MRS. `csN` high is a deselect. Deselect and NOP are never illegal and change no state by themselves.
- R3: `bankStates` holds bank i in bits [3i+2:3i], coded 0 idle, 1 row active, 2 reading, 3 writing, 4 precharging. Every state change is visible one cycle after the edge that sampled its cause.
- R4: ACT to an idle bank makes it row active. ACT to a bank in any other state is illegal. ACT to one bank does not depend on the state of other banks.
- R5: READ or WRIT to an idle or precharging bank is illegal. To a row-active bank, READ starts a read burst lasting CAS_LAT+BURST_LEN-1 cycles and WRIT starts a write burst lasting BURST_LEN cycles. Without auto-precharge, the bank then returns to row active.
- R6: READ or WRIT to a bank that is already reading or writing is legal. It replaces the old burst with a full-length burst of the new kind.
- R7: A legal READ or WRIT to one bank ends at once any burst running on every other bank.
- R8: BST ends every running burst, returns those banks to row active and cancels their auto-precharge. In any other state BST has no effect, and BST is never illegal.
- R9: PRE with A10 low moves a row-active, reading or writing bank to precharging. It leaves idle and precharging banks unchanged and is never illegal. A precharging bank becomes idle T_RP cycles after the PRE.
- R10: PRE with A10 high moves every open bank to precharging, whatever the bank address.
- R11: READ or WRIT with A10 high marks auto-precharge. When that burst ends, whether naturally or because another bank was read or written, the bank goes to precharging and becomes idle T_RP cycles later.
- R12: REF and MRS are legal only when every bank is idle, and they leave all states unchanged.
- R13: An illegal command changes no bank state. `illegalFlag` is high for exactly the cycle after it and `illegalBank` takes its bank address. `illegalBank` holds its value until the next illegal command.
- R14: While `cke` is low, no state or counter advances and `illegalFlag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable seen on the bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: all-bank / auto-precharge select |
| bankStates | output | 3·2^BA_W | Per-bank state codes |
| illegalFlag | output | 1 | One-cycle pulse after an illegal command |
| illegalBank | output | BA_W | Bank address of the latest illegal command |

## Verification
Every result is registered, so each output answers the command sampled at the previous rising edge. The bench drives inputs on the falling edge. At the next falling edge it compares `bankStates`, `illegalFlag` and `illegalBank` against a behavioural model stepped once for that same edge. Burst and precharge completions are not counted by the model. It records the absolute live-cycle index at which each one falls due, so that a late or early exit shows up as a state mismatch in exactly the cycle it occurs. Cycles with `cke` low do not advance that index.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_ACTIVE = 3'd1,
    BK_READ   = 3'd2,
    BK_WRITE  = 3'd3,
    BK_PRECH  = 3'd4
  } bankState_e;

  // Values equal the {rasN,casN,weN} pin pattern
  typedef enum logic [2:0] {
    CMD_MRS  = 3'b000,
    CMD_REF  = 3'b001,
    CMD_PRE  = 3'b010,
    CMD_ACT  = 3'b011,
    CMD_WRIT = 3'b100,
    CMD_READ = 3'b101,
    CMD_BST  = 3'b110,
    CMD_NOP  = 3'b111
  } cmd_e;

  // Strobes from the command judge to the bank tracker
  typedef struct packed {
    logic live;     // cke high: clocks advance
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic bst;
    logic autoPre;
    logic illegal;
  } bankStrobe_t;

endpackage

// File: rtl/sdm_cmd_judge.sv
module sdm_cmd_judge
  import sdm_pkg::*;
#(
  parameter int BA_W = 2,
  localparam int NB = 1 << BA_W
) (
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              a10,
  input  logic [BA_W-1:0]   ba,
  input  logic [3*NB-1:0]   bankStates,
  output bankStrobe_t       stb
);

  bankState_e stArr [NB];
  logic       allIdle;
  bankState_e selSt;
  logic       selOpen;
  cmd_e       cmd;
  logic       issue;

  for (genvar i = 0; i < NB; i++) begin : gUnpack
    assign stArr[i] = bankState_e'(bankStates[3*i +: 3]);
  end

  always_comb begin
    allIdle = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (stArr[i] != BK_IDLE) allIdle = 1'b0;
    end
  end

  assign selSt   = stArr[ba];
  assign selOpen = (selSt == BK_ACTIVE) || (selSt == BK_READ) || (selSt == BK_WRITE);
  assign cmd     = cmd_e'({rasN, casN, weN});
  assign issue   = cke && !csN;

  always_comb begin
    stb      = '0;
    stb.live = cke;
    if (issue) begin
      unique case (cmd)
        CMD_ACT: begin
          if (selSt == BK_IDLE) stb.act = 1'b1;
          else                  stb.illegal = 1'b1;
        end
        CMD_READ, CMD_WRIT: begin
          if (selOpen) begin
            stb.rd      = (cmd == CMD_READ);
            stb.wr      = (cmd == CMD_WRIT);
            stb.autoPre = a10;
          end else begin
            stb.illegal = 1'b1;
          end
        end
        CMD_PRE: begin
          stb.pre    = 1'b1;
          stb.preAll = a10;
        end
        CMD_REF, CMD_MRS: begin
          if (!allIdle) stb.illegal = 1'b1;
        end
        CMD_BST: stb.bst = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdm_bank_track.sv
module sdm_bank_track
  import sdm_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  localparam int NB      = 1 << BA_W,
  localparam int RD_LEN  = CAS_LAT + BURST_LEN - 1,
  localparam int WR_LEN  = BURST_LEN,
  localparam int MAX_A   = (T_RP > RD_LEN) ? T_RP : RD_LEN,
  localparam int MAX_L   = (MAX_A > WR_LEN) ? MAX_A : WR_LEN,
  localparam int CNT_W   = $clog2(MAX_L + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  bankStrobe_t       stb,
  input  logic [BA_W-1:0]   ba,
  output logic [3*NB-1:0]   bankStates,
  output logic              illegalFlag,
  output logic [BA_W-1:0]   illegalBank
);

  localparam logic [CNT_W-1:0] RP_LD = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_LEN - 1);

  for (genvar i = 0; i < NB; i++) begin : gBank
    bankState_e       st, nSt;
    logic [CNT_W-1:0] cnt, nCnt;
    logic             ap, nAp;
    logic             hit, busy, open, rw;

    assign hit  = (ba == BA_W'(i));
    assign busy = (st == BK_READ) || (st == BK_WRITE);
    assign open = busy || (st == BK_ACTIVE);
    assign rw   = stb.rd || stb.wr;

    always_comb begin
      nSt  = st;
      nCnt = cnt;
      nAp  = ap;
      // timed exits
      if (st == BK_PRECH) begin
        if (cnt == '0) nSt = BK_IDLE;
        else           nCnt = cnt - 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          nSt  = ap ? BK_PRECH : BK_ACTIVE;
          nCnt = RP_LD;
          nAp  = 1'b0;
        end else begin
          nCnt = cnt - 1'b1;
        end
      end
      // commands take precedence over timed exits
      if (stb.pre && (stb.preAll || hit) && open) begin
        nSt  = BK_PRECH;
        nCnt = RP_LD;
        nAp  = 1'b0;
      end else if (stb.act && hit) begin
        nSt = BK_ACTIVE;
      end else if (rw && hit) begin
        nSt  = stb.rd ? BK_READ : BK_WRITE;
        nCnt = stb.rd ? RD_LD : WR_LD;
        nAp  = stb.autoPre;
      end else if (rw && busy) begin
        nSt  = ap ? BK_PRECH : BK_ACTIVE;
        nCnt = RP_LD;
        nAp  = 1'b0;
      end else if (stb.bst && busy) begin
        nSt = BK_ACTIVE;
        nAp = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st  <= BK_IDLE;
        cnt <= '0;
        ap  <= 1'b0;
      end else if (stb.live) begin
        st  <= nSt;
        cnt <= nCnt;
        ap  <= nAp;
      end
    end

    assign bankStates[3*i +: 3] = st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegalFlag <= 1'b0;
      illegalBank <= '0;
    end else begin
      illegalFlag <= stb.illegal;
      if (stb.illegal) illegalBank <= ba;
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdm_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke,
  input  logic                  csN,
  input  logic                  rasN,
  input  logic                  casN,
  input  logic                  weN,
  input  logic [BA_W-1:0]       ba,
  input  logic                  a10,
  output logic [(3<<BA_W)-1:0]  bankStates,
  output logic                  illegalFlag,
  output logic [BA_W-1:0]       illegalBank
);

  bankStrobe_t stb;

  sdm_cmd_judge #(.BA_W(BA_W)) judge (
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .ba(ba), .bankStates(bankStates), .stb(stb)
  );

  sdm_bank_track #(
    .BA_W(BA_W), .T_RP(T_RP), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) track (
    .clk(clk), .rst(rst), .stb(stb), .ba(ba),
    .bankStates(bankStates), .illegalFlag(illegalFlag), .illegalBank(illegalBank)
  );

endmodule

// File: rtl/sdm_monitor_checker.sv
module sdm_monitor_checker #(
  parameter int BA_W = 2,
  localparam int NB = 1 << BA_W
) (
  input logic               clk,
  input logic               rst,
  input logic               cke,
  input logic               csN,
  input logic               rasN,
  input logic               casN,
  input logic               weN,
  input logic [BA_W-1:0]    ba,
  input logic               a10,
  input logic [3*NB-1:0]    bankStates,
  input logic               illegalFlag,
  input logic [BA_W-1:0]    illegalBank
);

  logic [2:0]      stArr [NB];
  logic            rstQ = 1'b0;
  logic [BA_W-1:0] baQ  = '0;
  logic            badEnc, allIdle, issue;
  logic [2:0]      code;

  for (genvar i = 0; i < NB; i++) begin : gSt
    assign stArr[i] = bankStates[3*i +: 3];
  end

  always_comb begin
    badEnc  = 1'b0;
    allIdle = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (stArr[i] > 3'd4)  badEnc  = 1'b1;
      if (stArr[i] != 3'd0) allIdle = 1'b0;
    end
  end

  assign issue = cke && !csN;
  assign code  = {rasN, casN, weN};

  always_ff @(posedge clk) begin
    rstQ <= rst;
    baQ  <= ba;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rstQ |-> (bankStates == '0) && !illegalFlag && (illegalBank == '0));

  a_r2_nop_legal: assert property (@(posedge clk) disable iff (rst)
    (cke && (csN || code == 3'b111)) |=> !illegalFlag);

  a_r3_encoding: assert property (@(posedge clk) disable iff (rst)
    !badEnc);

  a_r4_act_busy: assert property (@(posedge clk) disable iff (rst)
    (issue && code == 3'b011 && stArr[ba] != 3'd0) |=> illegalFlag);

  a_r5_rw_closed: assert property (@(posedge clk) disable iff (rst)
    (issue && code[2:1] == 2'b10 && (stArr[ba] == 3'd0 || stArr[ba] == 3'd4)) |=> illegalFlag);

  a_r9_pre_closes: assert property (@(posedge clk) disable iff (rst)
    (issue && code == 3'b010 && !a10 && stArr[ba] >= 3'd1 && stArr[ba] <= 3'd3)
      |=> (stArr[baQ] == 3'd4));

  a_r12_ref_busy: assert property (@(posedge clk) disable iff (rst)
    (issue && code[2:1] == 2'b00 && !allIdle) |=> illegalFlag);

  a_r14_cke_freeze: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(bankStates) && !illegalFlag));

endmodule

bind sdram_cmd_monitor sdm_monitor_checker #(.BA_W(BA_W)) chk (
  .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .a10(a10), .bankStates(bankStates),
  .illegalFlag(illegalFlag), .illegalBank(illegalBank)
);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  localparam int BA_W = 2;
  localparam int NB = 1 << BA_W;
  localparam int T_RP = 3;
  localparam int CAS_LAT = 2;
  localparam int BURST_LEN = 4;
  localparam int RD_LEN = CAS_LAT + BURST_LEN - 1;
  localparam int WR_LEN = BURST_LEN;

  localparam int C_MRS = 0, C_REF = 1, C_PRE = 2, C_ACT = 3;
  localparam int C_WR = 4, C_RD = 5, C_BST = 6, C_NOP = 7;

  logic clk = 1'b0;
  logic rst = 1'b1, cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, a10 = 1'b0;
  logic [BA_W-1:0]   ba = '0;
  logic [3*NB-1:0]   bankStates;
  logic              illegalFlag;
  logic [BA_W-1:0]   illegalBank;

  always #2 clk = ~clk;

  sdram_cmd_monitor #(.BA_W(BA_W), .T_RP(T_RP), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) uut (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .a10(a10), .bankStates(bankStates), .illegalFlag(illegalFlag),
    .illegalBank(illegalBank)
  );

  // behavioural model: state, due cycle of the next timed exit, auto-precharge mark
  int    mSt [NB];
  int    mDue [NB];
  bit    mAp [NB];
  int    liveN = 0;
  bit    mIll = 0;
  int    mBank = 0;
  bit    mValid = 0;
  string mTag = "R1";
  int    tests = 0, fails = 0;
  bit    done = 0;

  task automatic check();
    logic [3*NB-1:0] e;
    if (!mValid) return;
    for (int b = 0; b < NB; b++) e[3*b +: 3] = 3'(mSt[b]);
    tests++;
    if (bankStates !== e || illegalFlag !== mIll || illegalBank !== BA_W'(mBank)) begin
      fails++;
      $display("FAIL %s: states=%h ill=%b bank=%0d, expected states=%h ill=%b bank=%0d",
               mTag, bankStates, illegalFlag, illegalBank, e, mIll, mBank);
    end
  endtask

  task automatic closeBurst(int b);
    if (mAp[b]) begin mSt[b] = 4; mDue[b] = liveN + T_RP; end
    else mSt[b] = 1;
    mAp[b] = 0;
  endtask

  task automatic step(string tag);
    int code, sel;
    bit allIdle, open, bad, doAct, doRw, isRd, doPre, doBst;
    mTag = tag;
    mValid = 1;
    if (rst) begin
      for (int b = 0; b < NB; b++) begin mSt[b] = 0; mAp[b] = 0; mDue[b] = 0; end
      mIll = 0; mBank = 0;
      return;
    end
    if (!cke) begin mIll = 0; return; end
    liveN++;
    code = int'({rasN, casN, weN});
    sel = int'(ba);
    allIdle = 1;
    for (int b = 0; b < NB; b++) if (mSt[b] != 0) allIdle = 0;
    open = (mSt[sel] >= 1 && mSt[sel] <= 3);
    bad = 0; doAct = 0; doRw = 0; isRd = 0; doPre = 0; doBst = 0;
    if (!csN) begin
      case (code)
        C_ACT: if (mSt[sel] == 0) doAct = 1; else bad = 1;
        C_RD, C_WR: if (open) begin doRw = 1; isRd = (code == C_RD); end else bad = 1;
        C_PRE: doPre = 1;
        C_REF, C_MRS: if (!allIdle) bad = 1;
        C_BST: doBst = 1;
        default: ;
      endcase
    end
    for (int b = 0; b < NB; b++) begin
      bit busy0 = (mSt[b] == 2 || mSt[b] == 3);
      bit open0 = busy0 || mSt[b] == 1;
      if (mSt[b] == 4 && liveN == mDue[b]) mSt[b] = 0;
      else if (busy0 && liveN == mDue[b]) closeBurst(b);
      if (doPre && (a10 || b == sel) && open0) begin
        mSt[b] = 4; mDue[b] = liveN + T_RP; mAp[b] = 0;
      end else if (doAct && b == sel) begin
        mSt[b] = 1;
      end else if (doRw && b == sel) begin
        mSt[b] = isRd ? 2 : 3;
        mDue[b] = liveN + (isRd ? RD_LEN : WR_LEN);
        mAp[b] = a10;
      end else if (doRw && busy0) begin
        closeBurst(b);
      end else if (doBst && busy0) begin
        mSt[b] = 1; mAp[b] = 0;
      end
    end
    mIll = bad;
    if (bad) mBank = sel;
  endtask

  task automatic cyc(string tag, bit r, bit k, bit cs, int code, int bank, bit a);
    @(negedge clk);
    check();
    rst = r; cke = k; csN = cs;
    {rasN, casN, weN} = 3'(code);
    ba = BA_W'(bank); a10 = a;
    step(tag);
  endtask

  task automatic go(string tag, int code, int bank, bit a = 0);
    cyc(tag, 0, 1, 0, code, bank, a);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 1, 1, C_NOP, 0, 0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin mSt[b] = 0; mDue[b] = 0; mAp[b] = 0; end
    // R1 reset
    for (int i = 0; i < 3; i++) cyc("R1", 1, 1, 1, C_NOP, 0, 0);
    idle("R1", 2);
    // R2 NOP and deselect
    go("R2", C_NOP, 1); go("R2", C_NOP, 3); idle("R2", 2);
    // R4 activate
    go("R4", C_ACT, 0); idle("R4", 1); go("R4", C_ACT, 0); go("R4", C_ACT, 1);
    // R5 bursts and closed-bank access
    go("R5", C_RD, 2); go("R5", C_WR, 3);
    go("R5", C_RD, 0); idle("R5", 7);
    go("R5", C_WR, 1); idle("R5", 6);
    // R6 restart of a running burst
    go("R6", C_RD, 0); idle("R6", 2); go("R6", C_RD, 0); idle("R6", 2);
    go("R6", C_WR, 0); idle("R6", 6);
    // R7 cross-bank burst termination
    go("R7", C_RD, 0); go("R7", C_WR, 1); idle("R7", 7);
    // R8 burst stop
    go("R8", C_RD, 0, 1); idle("R8", 1); go("R8", C_BST, 0); idle("R8", 7);
    go("R8", C_BST, 2); idle("R8", 1);
    // R9 single-bank precharge
    go("R9", C_PRE, 0); go("R9", C_ACT, 0); go("R9", C_RD, 0); idle("R9", 4);
    go("R9", C_PRE, 2); idle("R9", 1);
    // R10 all-bank precharge
    go("R10", C_ACT, 0); go("R10", C_ACT, 2); go("R10", C_PRE, 3, 1); idle("R10", 5);
    // R11 auto-precharge, natural end and end forced by another bank
    go("R11", C_ACT, 0); go("R11", C_ACT, 1); go("R11", C_WR, 0, 1); idle("R11", 8);
    go("R11", C_ACT, 0); idle("R11", 1); go("R11", C_RD, 0, 1); go("R11", C_WR, 1); idle("R11", 8);
    // R12 global commands
    go("R12", C_REF, 0); go("R12", C_MRS, 2); go("R12", C_PRE, 0, 1); idle("R12", 4);
    go("R12", C_REF, 0); go("R12", C_MRS, 1); idle("R12", 1);
    // R13 illegal reporting and hold of the bank number
    go("R13", C_ACT, 2); go("R13", C_ACT, 2); go("R13", C_RD, 3); idle("R13", 3);
    go("R13", C_REF, 1); go("R13", C_ACT, 2); idle("R13", 2);
    // R14 clock enable low
    go("R14", C_RD, 2);
    for (int i = 0; i < 4; i++) cyc("R14", 0, 0, 0, C_ACT, 2, 0);
    go("R14", C_ACT, 2);
    for (int i = 0; i < 2; i++) cyc("R14", 0, 0, 1, C_NOP, 0, 0);
    idle("R14", 7);
    // R3 mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int code = int'($urandom_range(7, 0));
      if (code <= C_REF && $urandom_range(3, 0) != 0) code = C_NOP;
      cyc("R3", ($urandom_range(499, 0) == 0), ($urandom_range(9, 0) != 0),
          ($urandom_range(4, 0) == 0), code, int'($urandom_range(NB - 1, 0)),
          ($urandom_range(9, 0) < 3));
    end
    @(negedge clk);
    check();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule